// File: doc/BRIEF.md
# Sequential Unsigned Divider With Exceptions

This block divides an unsigned dividend of twice the word width, presented as an upper and a lower word, by a one-word divisor. It returns a one-word quotient and a one-word remainder. The work is done one quotient bit per clock. Each step either adds or subtracts the divisor, depending on the sign of the running partial remainder, and never restores it. A single correction at the end makes the remainder non-negative.

Two conditions are caught in the cycle that a request is accepted, and in both cases the iteration does not run:
- a zero divisor;
- an upper dividend word that is not below the divisor, which would give a quotient too wide for one word.

Either one is reported on its own flag, with a one-cycle completion pulse. A host pulses `start` with the operands in place and waits for `done`. The results then stay on the outputs until the next operation completes.

Top module: `udiv_nonrestore`

## Requirements
- R1: While `rst_n` is low at a rising edge, and after that edge, `done`, `quotient`, `remainder`, `div_by_zero` and `overflow` are all 0.
- R2: A `start` accepted with `divisor` equal to 0 raises `done` after the very next rising edge, with `div_by_zero`=1, `overflow`=0, `quotient`=0 and `remainder`=0.
- R3: A `start` accepted with a non-zero `divisor` and `dividend_hi` >= `divisor` raises `done` after the very next rising edge, with `overflow`=1, `div_by_zero`=0, `quotient`=0 and `remainder`=0.
- R4: Otherwise, with N = `dividend_hi`·2^W + `dividend_lo`, the results are `quotient` = floor(N / `divisor`) and `remainder` = N mod `divisor`, and both flags are 0. For example, 117 / 10 gives 11 rem 7.
- R5: A non-error operation raises `done` after the (W+1)-th rising edge counted from, and including, the edge that accepted `start`.
- R6: `done` is high for exactly one cycle per accepted operation.
- R7: A `start` seen while an operation is in progress is ignored. The running operation finishes with its original operands and its original timing, and no extra result is produced.
- R8: `quotient`, `remainder`, `div_by_zero` and `overflow` change only in the cycle in which `done` is high, and hold their values otherwise.
- R9: If the last step leaves a negative partial remainder, the divisor is added back once, so the reported remainder is always below the divisor.
- R10: Boundary operands divide correctly:
  - the largest divisor, with `dividend_hi` one below it, gives the largest quotient;
  - a divisor of 1 returns `dividend_lo` as the quotient;
  - a zero dividend returns 0 rem 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a division; honoured only when idle |
| dividend_hi | input | W | Upper word of the dividend |
| dividend_lo | input | W | Lower word of the dividend |
| divisor | input | W | Divisor |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient of the last operation |
| remainder | output | W | Remainder of the last operation |
| div_by_zero | output | 1 | Last operation had a zero divisor |
| overflow | output | 1 | Last operation's quotient would not fit in W bits |

## Verification
The divider is driven with these operand patterns:
- the worked value 117 / 10;
- an upper word just below the divisor, which yields the widest quotient;
- a unit divisor and a zero dividend;
- a zero divisor and an upper word equal to the divisor;
- a long pseudo-random series, most of it legal and about one case in five unconstrained.

Legal cases with both even and odd partial-remainder sign histories show whether the add/subtract choice and the final correction are right. The two error patterns show whether the zero check takes priority and whether the one-cycle latency holds. A second `start` pulsed mid-operation with a zero divisor tells apart a design that ignores busy requests from one that restarts or flags an error.

// File: rtl/udiv_pkg.sv
// Package: shared definitions for the sequential unsigned divider.
// Assumes: nothing beyond IEEE 1800-2017.
package udiv_pkg;

    // Controller phases: waiting for a request, or iterating.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } udiv_state_e;

endpackage

// File: rtl/udiv_precheck.sv
// Module: udiv_precheck
// Classifies a request before any iteration: a zero divisor, or an upper
// dividend word too large for the quotient to fit in W bits.
// Assumes: the zero check has priority, so at most one flag is set.
module udiv_precheck #(
    parameter int W = 8
) (
    input  logic [W-1:0] upper,
    input  logic [W-1:0] dvsr,
    output logic         zero_dvsr,
    output logic         too_wide
);

    // Decode the two exception conditions.
    always_comb begin
        zero_dvsr = (dvsr == '0);
        too_wide  = !zero_dvsr && (upper >= dvsr);
    end

endmodule

// File: rtl/udiv_nr_step.sv
// Module: udiv_nr_step
// One nonrestoring iteration. The partial remainder is shifted left and
// takes the top bit of the quotient/low word. The divisor is then
// subtracted if the old remainder was non-negative, or added if it was
// negative. The quotient bit is the inverted sign of the result.
// Assumes: the incoming remainder lies in [-d, d), so the result does too
// and fits in W+1 signed bits; the shift is done at W+2 bits.
module udiv_nr_step #(
    parameter int W = 8
) (
    input  logic [W:0]   prem,
    input  logic [W-1:0] qword,
    input  logic [W-1:0] dvsr,
    output logic [W:0]   prem_nxt,
    output logic [W-1:0] qword_nxt
);

    logic [W+1:0] shifted;
    logic [W+1:0] dvsr_x;
    logic [W+1:0] sum;

    // Shift, then add or subtract the divisor, choosing by the old sign.
    always_comb begin
        shifted   = {prem, qword[W-1]};
        dvsr_x    = {2'b00, dvsr};
        sum       = prem[W] ? (shifted + dvsr_x) : (shifted - dvsr_x);
        prem_nxt  = sum[W:0];
        qword_nxt = {qword[W-2:0], ~sum[W+1]};
    end

endmodule

// File: rtl/udiv_rem_fix.sv
// Module: udiv_rem_fix
// Final remainder correction: adds the divisor back once when the last
// partial remainder is negative.
// Assumes: the partial remainder lies in [-d, d), so the corrected value
// lies in [0, d) and fits in W bits.
module udiv_rem_fix #(
    parameter int W = 8
) (
    input  logic [W:0]   prem,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] rem
);

    // Pick the corrected or the raw low word.
    always_comb begin
        rem = prem[W] ? (prem[W-1:0] + dvsr) : prem[W-1:0];
    end

endmodule

// File: rtl/udiv_nonrestore.sv
// Module: udiv_nonrestore
// Top of the sequential unsigned divider: a 2W-bit dividend divided by a
// W-bit divisor, in W nonrestoring steps with exception prechecks.
// Assumes: W >= 2; start is sampled only while idle; results and flags
// are written only in the cycle done is high, and held otherwise.
module udiv_nonrestore #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero,
    output logic         overflow
);
    import udiv_pkg::*;

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    udiv_state_e  state;
    logic [CW-1:0] step_cnt;
    logic [W:0]   prem_r;
    logic [W-1:0] qword_r;
    logic [W-1:0] dvsr_r;

    logic         zero_dvsr;
    logic         too_wide;
    logic [W:0]   prem_nxt;
    logic [W-1:0] qword_nxt;
    logic [W-1:0] rem_fixed;

    udiv_precheck #(.W(W)) u_check (
        .upper     (dividend_hi),
        .dvsr      (divisor),
        .zero_dvsr (zero_dvsr),
        .too_wide  (too_wide)
    );

    udiv_nr_step #(.W(W)) u_step (
        .prem      (prem_r),
        .qword     (qword_r),
        .dvsr      (dvsr_r),
        .prem_nxt  (prem_nxt),
        .qword_nxt (qword_nxt)
    );

    udiv_rem_fix #(.W(W)) u_fix (
        .prem (prem_nxt),
        .dvsr (dvsr_r),
        .rem  (rem_fixed)
    );

    // Controller and datapath registers: accept, iterate, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            step_cnt    <= '0;
            prem_r      <= '0;
            qword_r     <= '0;
            dvsr_r      <= '0;
            done        <= 1'b0;
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
            overflow    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (zero_dvsr || too_wide) begin
                            done        <= 1'b1;
                            div_by_zero <= zero_dvsr;
                            overflow    <= too_wide;
                            quotient    <= '0;
                            remainder   <= '0;
                        end else begin
                            prem_r   <= {1'b0, dividend_hi};
                            qword_r  <= dividend_lo;
                            dvsr_r   <= divisor;
                            step_cnt <= '0;
                            state    <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    prem_r   <= prem_nxt;
                    qword_r  <= qword_nxt;
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == LAST_STEP) begin
                        done        <= 1'b1;
                        quotient    <= qword_nxt;
                        remainder   <= rem_fixed;
                        div_by_zero <= 1'b0;
                        overflow    <= 1'b0;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a zero divisor completes on the next edge with only its own flag.
    assert_zero_dvsr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && divisor == '0)
        |=> (done && div_by_zero && !overflow));

    // R3: a too-large upper word completes on the next edge with the overflow flag.
    assert_quot_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && divisor != '0 && dividend_hi >= divisor)
        |=> (done && overflow && !div_by_zero));

    // R4: a legal result always has a remainder below its divisor.
    assert_rem_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero && !overflow) |-> (remainder < dvsr_r));

    // R9: while iterating, the partial remainder stays inside [-d, d).
    assert_prem_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |->
        (prem_r[W] ? ((~prem_r + 1'b1) <= {1'b0, dvsr_r}) : (prem_r < {1'b0, dvsr_r})));

    // R7: a busy divider keeps its operand whatever start does.
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(dvsr_r));

    // R6: done falls after one cycle when no new request follows.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R8: results do not move on an edge that does not raise done.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(!rst_n) && !done) |-> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/udiv_nonrestore_test.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them when done is seen.
module udiv_nonrestore_test;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         z;
        logic         o;
        int           lat;
        int           t0;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] hi = '0;
    logic [W-1:0] lo = '0;
    logic [W-1:0] dv = '0;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_by_zero;
    logic         overflow;

    exp_t         sb[$];
    exp_t         cur;
    int           cyc = 0;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           mon_on = 1'b0;
    bit           prev_done = 1'b0;
    logic [W-1:0] held_q = '0;
    logic [W-1:0] held_r = '0;
    logic         held_z = 1'b0;
    logic         held_o = 1'b0;
    logic [31:0]  rng = 32'h1234_5678;

    udiv_nonrestore #(.W(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend_hi (hi),
        .dividend_lo (lo),
        .divisor     (dv),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_by_zero (div_by_zero),
        .overflow    (overflow)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Monitor: compare results on done, and check holding and pulse width.
    always @(negedge clk) begin
        if (mon_on) begin
            if (done) begin
                chk(!prev_done, "R6", "done high two cycles", 1, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", "result with nothing pending", 1, 0);
                end else begin
                    cur = sb.pop_front();
                    chk(quotient == cur.q, cur.tag, "quotient", quotient, cur.q);
                    chk(remainder == cur.r, cur.tag, "remainder", remainder, cur.r);
                    chk(div_by_zero == cur.z, cur.tag, "div_by_zero", div_by_zero, cur.z);
                    chk(overflow == cur.o, cur.tag, "overflow", overflow, cur.o);
                    chk(cyc - cur.t0 == cur.lat, "R5", "latency", cyc - cur.t0, cur.lat);
                end
                held_q = quotient;
                held_r = remainder;
                held_z = div_by_zero;
                held_o = overflow;
            end else begin
                chk(quotient == held_q && remainder == held_r &&
                    div_by_zero == held_z && overflow == held_o,
                    "R8", "outputs moved without done",
                    {quotient, remainder}, {held_q, held_r});
            end
            prev_done = done;
        end
    end

    // Driver: issue one operation, optionally poke start while busy.
    task automatic run_op(input logic [W-1:0] h, input logic [W-1:0] l,
                          input logic [W-1:0] d, input bit poke, input string tag);
        exp_t e;
        logic [2*W-1:0] num;
        num = {h, l};
        e.z = (d == '0);
        e.o = (d != '0) && (h >= d);
        e.tag = tag;
        if (e.z || e.o) begin
            e.q = '0;
            e.r = '0;
            e.lat = 1;
        end else begin
            e.q = W'(num / d);
            e.r = W'(num % d);
            e.lat = W + 1;
        end
        @(negedge clk);
        hi = h;
        lo = l;
        dv = d;
        start = 1'b1;
        e.t0 = cyc;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (poke && !e.z && !e.o) begin
            @(negedge clk);
            hi = ~h;
            lo = ~l;
            dv = '0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && quotient == '0 && remainder == '0 &&
            div_by_zero == 1'b0 && overflow == 1'b0,
            "R1", "reset outputs", {done, quotient, remainder}, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        run_op(8'd0, 8'd117, 8'd10, 1'b0, "R4");
        run_op(8'd0, 8'd5, 8'd0, 1'b0, "R2");
        run_op(8'd200, 8'd5, 8'd0, 1'b0, "R2");
        run_op(8'd32, 8'd1, 8'd32, 1'b0, "R3");
        run_op(8'd255, 8'd255, 8'd3, 1'b0, "R3");
        run_op(8'd254, 8'd255, 8'd255, 1'b0, "R10");
        run_op(8'd0, 8'd171, 8'd1, 1'b0, "R10");
        run_op(8'd0, 8'd0, 8'd7, 1'b0, "R10");
        run_op(8'd99, 8'd200, 8'd100, 1'b0, "R10");
        run_op(8'd3, 8'd77, 8'd9, 1'b1, "R7");
        run_op(8'd0, 8'd250, 8'd251, 1'b1, "R7");

        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] d;
            logic [W-1:0] h;
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            d = rng[7:0];
            h = rng[15:8];
            if ((i % 5) != 0 && d != '0) h = h % d;
            run_op(h, rng[23:16], d, rng[24], "R9");
        end

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R6", "results still pending", sb.size(), 0);
        summary();
        $finish;
    end

endmodule